// File: doc/BRIEF.md
# Interleaved Multi-Bank Memory

This block is a small word-addressed memory split into equal banks behind one read/write port. Each access presents an address, and the block cuts it into a bank-select field and an in-bank offset. It raises a one-hot enable for the chosen bank, and only that bank acts on the access. Read data comes back from that bank one clock later.

A static mapping input sets which address bits choose the bank. In high-order mode the upper bits pick the bank, so consecutive words fill one bank before moving to the next. In low-order mode the lower bits pick the bank, so consecutive words rotate across all banks, which suits parallel or overlapped access to neighbouring words. The mapping may only change while no access is requested. Stored words stay where they are, and after a change the same storage is read through the other mapping.

With BANK_BITS select bits and OFFSET_BITS offset bits, the address is BANK_BITS + OFFSET_BITS wide and reaches 2^BANK_BITS banks of 2^OFFSET_BITS words each. The default is four banks of four 8-bit words with a 4-bit address.

Top module: `ilv_mem`

## Requirements
- R1: With map_low = 0 (high-order), the bank is addr[3:2] and the offset is addr[1:0]; address 4'b1000 drives bank_en = 4'b0100 (bank 2, offset 0).
- R2: With map_low = 1 (low-order), the bank is addr[1:0] and the offset is addr[3:2]; address 4'b1000 drives bank_en = 4'b0001 (bank 0, offset 2).
- R3: bank_en, with bit i standing for bank i, has exactly one bit set in any cycle where wr_en or rd_en is high, and is all zeros otherwise. It is combinational from the inputs.
- R4: A read requested with rd_en at one rising edge shows its word on rdata and raises rvalid after that edge. rvalid is low after any edge without rd_en, and rdata holds its last value.
- R5: In high-order mode, writing 16 consecutive values to addresses 0 to 15 puts the first four values in bank 0, the next four in bank 1, and so on. Reading them back in the same mode returns each value at its own address.
- R6: In low-order mode, writing 16 consecutive values to addresses 0 to 15 spreads them round-robin, so bank 0 holds the 1st, 5th, 9th and 13th values.
- R7: Changing map_low while idle moves no data. After the change, address a reads the word stored at the bank and offset that a decodes to under the new mode.
- R8: A write alters only the word at its own bank and offset. Every other word in every bank keeps its value.
- R9: When wr_en and rd_en are high together, the write takes effect at that edge and the read returns the word as it was before the write.
- R10: After reset, rdata is 0, rvalid is 0 and every stored word reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, clears storage and read outputs |
| map_low | input | 1 | Mapping: 0 high-order, 1 low-order; change only while idle |
| addr | input | 4 | Word address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| bank_en | output | 4 | One-hot enable of the bank being accessed |
| rdata | output | 8 | Read data, valid the cycle after a read request |
| rvalid | output | 1 | High in the cycle rdata carries a fresh read |

## Verification
A table of address and mode pairs checks the enable decode. The table includes the 1000 example and the extreme addresses, so that a swapped or misaligned select field gives a different enable. A full 16-word fill in each mode is read back both in its own mode and in the other mode. The own-mode read-back tells correct storage apart from an address that aliases. The cross-mode read-back shows whether the banks really hold the expected round-robin or block layout, or whether the data was only passed through. A single write followed by a full sweep shows whether a write leaks into another bank. A combined read and write to one address tells read-before-write apart from write-first.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  localparam int DEF_BANK_BITS   = 2;
  localparam int DEF_OFFSET_BITS = 2;
  localparam int DEF_DATA_W      = 8;

  typedef enum logic {
    MAP_HIGH = 1'b0,
    MAP_LOW  = 1'b1
  } map_e;

endpackage

// File: rtl/ilv_decode.sv
module ilv_decode
  import ilv_pkg::*;
#(
  parameter int BANK_BITS   = DEF_BANK_BITS,
  parameter int OFFSET_BITS = DEF_OFFSET_BITS,
  localparam int ADDR_W     = BANK_BITS + OFFSET_BITS,
  localparam int NUM_BANKS  = 1 << BANK_BITS
) (
  input  logic                   map_low,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   access,
  output logic [BANK_BITS-1:0]   bank_sel,
  output logic [OFFSET_BITS-1:0] bank_ofs,
  output logic [NUM_BANKS-1:0]   bank_en
);

  function automatic logic [BANK_BITS-1:0] sel_of(input logic [ADDR_W-1:0] a,
                                                  input map_e m);
    if (m == MAP_LOW) return a[BANK_BITS-1:0];
    else              return a[ADDR_W-1 -: BANK_BITS];
  endfunction

  function automatic logic [OFFSET_BITS-1:0] ofs_of(input logic [ADDR_W-1:0] a,
                                                    input map_e m);
    if (m == MAP_LOW) return a[ADDR_W-1 -: OFFSET_BITS];
    else              return a[OFFSET_BITS-1:0];
  endfunction

  map_e mode;
  assign mode     = map_e'(map_low);
  assign bank_sel = sel_of(addr, mode);
  assign bank_ofs = ofs_of(addr, mode);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_en
    assign bank_en[b] = access && (bank_sel == BANK_BITS'(b));
  end

endmodule

// File: rtl/ilv_bank.sv
module ilv_bank
  import ilv_pkg::*;
#(
  parameter int OFFSET_BITS = DEF_OFFSET_BITS,
  parameter int DATA_W      = DEF_DATA_W,
  localparam int DEPTH      = 1 << OFFSET_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [OFFSET_BITS-1:0] ofs,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rd_q
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Read samples the old word; a write in the same cycle lands after it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_q <= '0;
    end else if (en) begin
      if (rd_en) rd_q     <= mem[ofs];
      if (wr_en) mem[ofs] <= wdata;
    end
  end

endmodule

// File: rtl/ilv_rd_mux.sv
module ilv_rd_mux
  import ilv_pkg::*;
#(
  parameter int BANK_BITS  = DEF_BANK_BITS,
  parameter int DATA_W     = DEF_DATA_W,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rd_en,
  input  logic [BANK_BITS-1:0]              bank_sel,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_q,
  output logic [BANK_BITS-1:0]              rd_sel_q,
  output logic [DATA_W-1:0]                 rdata,
  output logic                              rvalid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sel_q <= '0;
      rvalid   <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rd_sel_q <= bank_sel;
    end
  end

  assign rdata = bank_q[rd_sel_q];

endmodule

// File: rtl/ilv_mem.sv
module ilv_mem
  import ilv_pkg::*;
#(
  parameter int BANK_BITS   = DEF_BANK_BITS,
  parameter int OFFSET_BITS = DEF_OFFSET_BITS,
  parameter int DATA_W      = DEF_DATA_W,
  localparam int ADDR_W     = BANK_BITS + OFFSET_BITS,
  localparam int NUM_BANKS  = 1 << BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 map_low,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 wr_en,
  input  logic                 rd_en,
  output logic [NUM_BANKS-1:0] bank_en,
  output logic [DATA_W-1:0]    rdata,
  output logic                 rvalid
);

  logic                             access;
  logic [BANK_BITS-1:0]             bank_sel;
  logic [OFFSET_BITS-1:0]           bank_ofs;
  logic [BANK_BITS-1:0]             rd_sel_q;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q;

  assign access = wr_en | rd_en;

  ilv_decode #(
    .BANK_BITS  (BANK_BITS),
    .OFFSET_BITS(OFFSET_BITS)
  ) u_decode (
    .map_low (map_low),
    .addr    (addr),
    .access  (access),
    .bank_sel(bank_sel),
    .bank_ofs(bank_ofs),
    .bank_en (bank_en)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ilv_bank #(
      .OFFSET_BITS(OFFSET_BITS),
      .DATA_W     (DATA_W)
    ) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (bank_en[b]),
      .wr_en(wr_en),
      .rd_en(rd_en),
      .ofs  (bank_ofs),
      .wdata(wdata),
      .rd_q (bank_q[b])
    );
  end

  ilv_rd_mux #(
    .BANK_BITS(BANK_BITS),
    .DATA_W   (DATA_W)
  ) u_rd_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .bank_sel(bank_sel),
    .bank_q  (bank_q),
    .rd_sel_q(rd_sel_q),
    .rdata   (rdata),
    .rvalid  (rvalid)
  );

endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk #(
  parameter int BANK_BITS   = 2,
  parameter int OFFSET_BITS = 2,
  parameter int DATA_W      = 8,
  localparam int ADDR_W     = BANK_BITS + OFFSET_BITS,
  localparam int NUM_BANKS  = 1 << BANK_BITS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 map_low,
  input logic [ADDR_W-1:0]    addr,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [NUM_BANKS-1:0] bank_en,
  input logic [DATA_W-1:0]    rdata,
  input logic                 rvalid,
  input logic [BANK_BITS-1:0] rd_sel_q
);

  AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |-> ($countones(bank_en) == 1)); // R3

  AST_EN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en || rd_en) |-> (bank_en == '0)); // R3

  AST_HIGH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_low && (wr_en || rd_en)) |-> bank_en[addr[ADDR_W-1 -: BANK_BITS]]); // R1

  AST_LOW_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (map_low && (wr_en || rd_en)) |-> bank_en[addr[BANK_BITS-1:0]]); // R2

  AST_RVALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid); // R4

  AST_RVALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid); // R4

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R4

  AST_RD_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_sel_q)); // R4

  AST_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(map_low) |-> !(wr_en || rd_en)); // R7

endmodule

bind ilv_mem ilv_mem_chk #(
  .BANK_BITS  (BANK_BITS),
  .OFFSET_BITS(OFFSET_BITS),
  .DATA_W     (DATA_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .map_low (map_low),
  .addr    (addr),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .bank_en (bank_en),
  .rdata   (rdata),
  .rvalid  (rvalid),
  .rd_sel_q(rd_sel_q)
);

// File: tb/tb_ilv_mem.sv
`timescale 1ns/1ps
module tb_ilv_mem;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       map_low;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic       wr_en;
  logic       rd_en;
  logic [3:0] bank_en;
  logic [7:0] rdata;
  logic       rvalid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [7:0] got;

  // {map_low, addr, expected bank_en}
  localparam logic [8:0] VEC [12] = '{
    {1'b0, 4'b1000, 4'b0100},
    {1'b1, 4'b1000, 4'b0001},
    {1'b0, 4'b0000, 4'b0001},
    {1'b0, 4'b1111, 4'b1000},
    {1'b0, 4'b0101, 4'b0010},
    {1'b0, 4'b0011, 4'b0001},
    {1'b0, 4'b1100, 4'b1000},
    {1'b1, 4'b0011, 4'b1000},
    {1'b1, 4'b0101, 4'b0010},
    {1'b1, 4'b1111, 4'b1000},
    {1'b1, 4'b0110, 4'b0100},
    {1'b1, 4'b1100, 4'b0001}
  };

  always #5 clk = ~clk;

  ilv_mem dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .map_low(map_low),
    .addr   (addr),
    .wdata  (wdata),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .bank_en(bank_en),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic set_mode(input logic m);
    map_low = m;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [3:0] addr_of(input logic lo, input int bank, input int ofs);
    // bank in upper half for high-order, lower half for low-order
    if (lo) return 4'(ofs * 4 + bank);
    else    return 4'(bank * 4 + ofs);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; map_low = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 rdata after reset", rdata, 0);
    check("R10 rvalid after reset", rvalid, 0);
    check("R3 bank_en idle", bank_en, 0);
    rd(4'd5, got);
    check("R10 word after reset", got, 0);

    // R1 R2 R3 decode table
    for (int i = 0; i < 12; i++) begin
      set_mode(VEC[i][8]);
      addr  = VEC[i][7:4];
      rd_en = 1'b1;
      #1;
      check(VEC[i][8] ? "R2 low-order bank_en" : "R1 high-order bank_en",
            bank_en, VEC[i][3:0]);
      @(negedge clk);
      rd_en = 1'b0;
      #1;
      check("R3 bank_en zero when idle", bank_en, 0);
      check("R4 rvalid after read", rvalid, 1);
      @(negedge clk);
      check("R4 rvalid drops", rvalid, 0);
    end

    // R5 high-order fill, read back in the same mode
    set_mode(1'b0);
    for (int i = 0; i < 16; i++) wr(4'(i), 8'((i + 1) * 10));
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), got);
      check("R5 high-order readback", got, (i + 1) * 10);
    end
    // R4 hold: no read, rdata unchanged and rvalid low
    @(negedge clk);
    check("R4 rdata held", rdata, 160);
    check("R4 rvalid low when idle", rvalid, 0);

    // R7 reinterpret in low-order: addr a -> bank a%4, offset a/4
    set_mode(1'b1);
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), got);
      check("R7 low view of high fill", got, (addr_of(1'b0, i % 4, i / 4) + 1) * 10);
    end

    // R6 low-order fill
    for (int i = 0; i < 16; i++) wr(4'(i), 8'(200 + i));
    set_mode(1'b0);
    // high-order addresses 0..3 are bank 0: values 1st,5th,9th,13th
    for (int k = 0; k < 4; k++) begin
      rd(4'(k), got);
      check("R6 bank0 round robin", got, 200 + 4 * k);
    end
    for (int i = 4; i < 16; i++) begin
      rd(4'(i), got);
      check("R6 R7 high view of low fill", got, 200 + addr_of(1'b1, i / 4, i % 4));
    end

    // R8 isolation: one write, sweep all words in low-order mode
    set_mode(1'b1);
    wr(4'd6, 8'hAA);
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), got);
      check("R8 single write isolation", got, (i == 6) ? 8'hAA : 8'(200 + i));
    end

    // R9 read and write in the same cycle
    addr = 4'd9; wdata = 8'h5C; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R9 read returns old word", rdata, 200 + 9);
    rd(4'd9, got);
    check("R9 write took effect", got, 8'h5C);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule